// File: doc/BRIEF.md
# Paged Address Translator with Hardware Table Walk

This block turns a 32-bit linear address into a 32-bit physical address for 4 KiB pages. It keeps a small fully associative cache of recent translations, tagged by the 20-bit virtual page number. When a lookup finds no usable entry, a walker state machine fetches the two levels of the page tables through a single-beat memory port. It marks entries it touches as accessed, and it marks the last-level entry as dirty on stores. It writes back any entry it changed, then installs the translation in the cache. If an entry at either level is absent, the request completes with a fault and the linear address is returned.

Requests enter on a valid/ready channel. The caller holds `req_valid`, `req_lin` and `req_write` steady until `req_ready` is seen high at a clock edge. `req_ready` stays low while a translation is in progress, so only one request is outstanding at a time. The result leaves on a valid/ready channel. `rsp_valid`, `rsp_addr` and `rsp_fault` stay fixed until the consumer raises `rsp_ready`. The memory port is also valid/ready: the block holds address, write flag and write data constant until `mem_ready`, and read data is taken in the same cycle as `mem_ready`. `dir_base` is sampled when a request is accepted. A one-cycle `flush` pulse empties the cache.

Top module: `pgx_translator`

## Requirements
- R1: On success `rsp_addr` is the 20-bit frame number in bits 31:12, and bits 11:0 are copied unchanged from the linear address. `rsp_fault` is 0.
- R2: A read that matches a cached page, or a write that matches a cached page already marked dirty, completes with no memory transaction.
- R3: On a miss, the first memory read is the directory entry at address {dir_base, lin[31:22], 2'b00}. The later table read is at {directory entry bits 31:12, lin[21:12], 2'b00}.
- R4: An entry that is present (bit 0 set) but has its accessed flag (bit 5) clear is written back to the same address with bit 5 set, before the walk goes on. An entry whose bit 5 is already set is not written.
- R5: A write access that walks sets the dirty flag (bit 6) in the last-level entry. The updated entry is written back to memory, and the returned frame is bits 31:12 of that entry.
- R6: A directory or table entry with bit 0 clear ends the walk. The response then has `rsp_fault`=1 and `rsp_addr` equal to the linear address. The absent entry is not written, and nothing is cached, so a repeat of the access walks again.
- R7: A write that matches a cached page not yet marked dirty performs a walk that sets the dirty flag in memory. A later write to that page completes without memory traffic.
- R8: New pages are placed in slots 0,1,2,… by a round-robin pointer. When the cache holds 32 pages, the 33rd replaces the page installed first and leaves the others in place. A page re-walked while cached reuses its slot.
- R9: A one-cycle `flush` invalidates every entry and returns the round-robin pointer to slot 0. The next access to a page cached earlier walks the tables.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds its values and `req_ready` stays low.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| dir_base | input | 20 | Frame number of the directory table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a store |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Physical address, or linear address on fault |
| rsp_fault | output | 1 | Page not present |
| mem_valid | output | 1 | Memory transaction offered |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with mem_ready |

## Verification
The bench targets a store that hits a clean cached page. A design that trusted the hit would leave the dirty flag clear in memory, and this shows up as a missing write transaction. It checks that an absent entry at either level yields a fault carrying the linear address and leaves nothing cached. A design that filled on a fault would answer the repeat access with no memory traffic. Replacement is probed by filling all 32 slots and adding one more page: a wrong pointer would evict a page other than the first one installed. A flush that missed the pointer or some entries would show up as hits where walks are expected. The memory model delays its ready, and the consumer stalls the response, to catch outputs that drift during a stall.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int ADDR_W       = 32;
  localparam int OFS_W        = 12;
  localparam int VPN_W        = ADDR_W - OFS_W;
  localparam int LVL_W        = VPN_W / 2;
  localparam int PRESENT_BIT  = 0;
  localparam int ACCESSED_BIT = 5;
  localparam int DIRTY_BIT    = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_DIR_RD, ST_DIR_WR,
    ST_TBL_RD, ST_TBL_WR, ST_FILL, ST_RESP
  } walk_st_t;

  typedef struct packed {
    logic             vld;
    logic             dirty;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] pfn;
  } tlb_ent_t;
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb
  import pgx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [VPN_W-1:0] hit_pfn,
  output logic             hit_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_pfn,
  input  logic             fill_dirty
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] slot_dirty;
  logic [VPN_W-1:0]   slot_pfn [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  assign hit = |hit_vec;

  // One slot per entry: storage, tag compare and write select.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    tlb_ent_t ent_r;

    assign hit_vec[i]    = ent_r.vld && (ent_r.vpn == look_vpn);
    assign wr_sel[i]     = fill_en && (hit ? hit_vec[i] : (rr_ptr == IDX_W'(i)));
    assign slot_dirty[i] = ent_r.dirty;
    assign slot_pfn[i]   = ent_r.pfn;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_r <= '0;
      end else if (flush) begin
        ent_r.vld <= 1'b0;
      end else if (wr_sel[i]) begin
        ent_r.vld   <= 1'b1;
        ent_r.dirty <= fill_dirty;
        ent_r.vpn   <= look_vpn;
        ent_r.pfn   <= fill_pfn;
      end
    end
  end

  always_comb begin
    hit_pfn   = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_pfn   = hit_pfn | slot_pfn[i];
        hit_dirty = hit_dirty | slot_dirty[i];
      end
    end
  end

  // Round-robin victim pointer advances only when a new slot is taken.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rr_ptr <= '0;
    end else if (fill_en && !hit) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8

  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit); // R9
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
  import pgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [VPN_W-1:0]  look_vpn,
  input  logic              hit,
  input  logic [VPN_W-1:0]  hit_pfn,
  input  logic              hit_dirty,
  output logic              fill_en,
  output logic [VPN_W-1:0]  fill_pfn,
  output logic              fill_dirty
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1) << ACCESSED_BIT;
  localparam logic [ADDR_W-1:0] D_MASK = ADDR_W'(1) << DIRTY_BIT;

  walk_st_t          st;
  logic [ADDR_W-1:0] lin_q;
  logic              wr_q;
  logic [VPN_W-1:0]  dbase_q;
  logic [VPN_W-1:0]  tbase_q;
  logic [ADDR_W-1:0] ent_q;
  logic [ADDR_W-1:0] out_q;
  logic              fault_q;
  logic [ADDR_W-1:0] tbl_upd;
  logic              dir_phase;

  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);
  assign rsp_addr   = out_q;
  assign rsp_fault  = fault_q;
  assign mem_valid  = (st == ST_DIR_RD) || (st == ST_DIR_WR) ||
                      (st == ST_TBL_RD) || (st == ST_TBL_WR);
  assign mem_we     = (st == ST_DIR_WR) || (st == ST_TBL_WR);
  assign dir_phase  = (st == ST_DIR_RD) || (st == ST_DIR_WR);
  assign mem_addr   = dir_phase ? {dbase_q, lin_q[ADDR_W-1 -: LVL_W], 2'b00}
                                : {tbase_q, lin_q[OFS_W +: LVL_W], 2'b00};
  assign mem_wdata  = ent_q;
  assign look_vpn   = lin_q[ADDR_W-1:OFS_W];
  assign fill_en    = (st == ST_FILL);
  assign fill_pfn   = ent_q[ADDR_W-1:OFS_W];
  assign fill_dirty = ent_q[DIRTY_BIT];
  assign tbl_upd    = mem_rdata | A_MASK | (wr_q ? D_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lin_q   <= '0;
      wr_q    <= 1'b0;
      dbase_q <= '0;
      tbase_q <= '0;
      ent_q   <= '0;
      out_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          lin_q   <= req_lin;
          wr_q    <= req_write;
          dbase_q <= dir_base;
          st      <= ST_LOOK;
        end
        ST_LOOK: begin
          if (hit && (!wr_q || hit_dirty)) begin
            out_q   <= {hit_pfn, lin_q[OFS_W-1:0]};
            fault_q <= 1'b0;
            st      <= ST_RESP;
          end else begin
            st <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: if (mem_ready) begin
          if (!mem_rdata[PRESENT_BIT]) begin
            out_q   <= lin_q;
            fault_q <= 1'b1;
            st      <= ST_RESP;
          end else begin
            tbase_q <= mem_rdata[ADDR_W-1:OFS_W];
            ent_q   <= mem_rdata | A_MASK;
            st      <= mem_rdata[ACCESSED_BIT] ? ST_TBL_RD : ST_DIR_WR;
          end
        end
        ST_DIR_WR: if (mem_ready) st <= ST_TBL_RD;
        ST_TBL_RD: if (mem_ready) begin
          if (!mem_rdata[PRESENT_BIT]) begin
            out_q   <= lin_q;
            fault_q <= 1'b1;
            st      <= ST_RESP;
          end else begin
            ent_q <= tbl_upd;
            st    <= (tbl_upd != mem_rdata) ? ST_TBL_WR : ST_FILL;
          end
        end
        ST_TBL_WR: if (mem_ready) st <= ST_FILL;
        ST_FILL: begin
          out_q   <= {ent_q[ADDR_W-1:OFS_W], lin_q[OFS_W-1:0]};
          fault_q <= 1'b0;
          st      <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && !req_ready && $stable(rsp_addr) && $stable(rsp_fault)); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[ACCESSED_BIT] && mem_wdata[PRESENT_BIT]); // R4

  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && (st == ST_TBL_WR) && wr_q |-> mem_wdata[DIRTY_BIT]); // R5
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [19:0] dir_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  logic [VPN_W-1:0] look_vpn;
  logic             hit;
  logic [VPN_W-1:0] hit_pfn;
  logic             hit_dirty;
  logic             fill_en;
  logic [VPN_W-1:0] fill_pfn;
  logic             fill_dirty;

  pgx_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_base  (dir_base),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_lin   (req_lin),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .look_vpn  (look_vpn),
    .hit       (hit),
    .hit_pfn   (hit_pfn),
    .hit_dirty (hit_dirty),
    .fill_en   (fill_en),
    .fill_pfn  (fill_pfn),
    .fill_dirty(fill_dirty)
  );

  pgx_tlb #(.ENTRIES(ENTRIES)) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .look_vpn  (look_vpn),
    .hit       (hit),
    .hit_pfn   (hit_pfn),
    .hit_dirty (hit_dirty),
    .fill_en   (fill_en),
    .fill_pfn  (fill_pfn),
    .fill_dirty(fill_dirty)
  );
endmodule

// File: tb/pgx_translator_test.sv
`timescale 1ns/1ps
module pgx_translator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [19:0] dir_base = 20'h00010;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pgx_translator uut (.*);

  // Memory model with varying latency and a transaction log.
  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_addr [16];
  logic        log_we   [16];
  logic [31:0] log_wd   [16];
  int          log_n = 0;
  int          wait_cnt = 0;
  int          dseq = 0;
  bit          held = 0;
  logic [31:0] held_addr = '0;
  int          hold_err = 0;

  always @(negedge clk) begin
    if (held && (!mem_valid || mem_addr != held_addr)) hold_err++;
    if (mem_valid) begin
      if (wait_cnt == 0) begin
        mem_ready = 1'b1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end else begin
        wait_cnt--;
        mem_ready = 1'b0;
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (log_n < 16) begin
        log_addr[log_n] = mem_addr;
        log_we[log_n]   = mem_we;
        log_wd[log_n]   = mem_wdata;
      end
      log_n++;
      if (mem_we) mem[mem_addr] = mem_wdata;
      wait_cnt = dseq % 3;
      dseq++;
      held = 0;
    end else if (mem_valid) begin
      held = 1;
      held_addr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] lin, input bit wr,
                       output logic [31:0] addr, output bit flt);
    log_n = 0;
    @(negedge clk);
    req_lin = lin; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    addr = rsp_addr;
    flt  = rsp_fault;
    @(negedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_valid, "R10", "reset idle outputs",
        {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);
  endtask

  task automatic t_first_walk();
    logic [31:0] a; bit f;
    xlate(32'h00401ABC, 1'b0, a, f);
    chk(a == 32'h12345ABC && !f, "R1", "walk result", a, 32'h12345ABC);
    chk(log_n == 4, "R4", "transaction count", log_n, 4);
    chk(log_addr[0] == 32'h00010004 && !log_we[0], "R3", "dir read addr", log_addr[0], 32'h00010004);
    chk(log_we[1] && log_wd[1] == 32'h00020021, "R4", "dir accessed writeback", log_wd[1], 32'h00020021);
    chk(log_addr[2] == 32'h00020004 && !log_we[2], "R3", "table read addr", log_addr[2], 32'h00020004);
    chk(log_we[3] && log_wd[3] == 32'h12345021, "R4", "table accessed writeback", log_wd[3], 32'h12345021);
  endtask

  task automatic t_hit();
    logic [31:0] a; bit f;
    xlate(32'h00401FFF, 1'b0, a, f);
    chk(a == 32'h12345FFF && !f, "R1", "hit offset passthrough", a, 32'h12345FFF);
    chk(log_n == 0, "R2", "hit memory traffic", log_n, 0);
  endtask

  task automatic t_clean_write_hit();
    logic [31:0] a; bit f;
    xlate(32'h00401000, 1'b1, a, f);
    chk(a == 32'h12345000 && !f, "R7", "clean write result", a, 32'h12345000);
    chk(log_n == 3, "R7", "clean write walks", log_n, 3);
    chk(log_we[2] && log_wd[2] == 32'h12345061, "R5", "dirty writeback", log_wd[2], 32'h12345061);
    xlate(32'h00401004, 1'b1, a, f);
    chk(log_n == 0 && a == 32'h12345004, "R7", "dirty write hit quiet", log_n, 0);
  endtask

  task automatic t_write_miss();
    logic [31:0] a; bit f;
    xlate(32'h00403010, 1'b1, a, f);
    chk(a == 32'h55555010 && !f, "R5", "write miss result", a, 32'h55555010);
    chk(log_n == 3 && log_we[2] && log_wd[2] == 32'h55555061, "R5", "write miss entry",
        log_wd[2], 32'h55555061);
  endtask

  task automatic t_faults();
    logic [31:0] a; bit f;
    xlate(32'h00C00123, 1'b0, a, f);
    chk(f && a == 32'h00C00123, "R6", "dir fault addr", a, 32'h00C00123);
    chk(log_n == 1 && !log_we[0], "R6", "dir fault traffic", log_n, 1);
    xlate(32'h00C00123, 1'b0, a, f);
    chk(f && log_n == 1, "R6", "dir fault repeat walks", log_n, 1);
    xlate(32'h00402567, 1'b1, a, f);
    chk(f && a == 32'h00402567, "R6", "table fault addr", a, 32'h00402567);
    chk(log_n == 2 && !log_we[0] && !log_we[1], "R6", "table fault no write", log_n, 2);
    xlate(32'h00402567, 1'b0, a, f);
    chk(f && log_n == 2, "R6", "table fault not cached", log_n, 2);
  endtask

  task automatic t_flush();
    logic [31:0] a; bit f;
    pulse_flush();
    xlate(32'h00401008, 1'b0, a, f);
    chk(log_n == 2 && a == 32'h12345008, "R9", "walk after flush", log_n, 2);
  endtask

  task automatic t_round_robin();
    logic [31:0] a; bit f;
    int misses = 0;
    pulse_flush();
    for (int i = 0; i < 33; i++)
      mem[32'h00020000 + 32'(4 * (16 + i))] = {20'hA0000 + 20'(i), 12'h021};
    for (int i = 0; i < 32; i++)
      xlate(32'h00400000 | (32'(16 + i) << 12), 1'b0, a, f);
    for (int i = 0; i < 32; i++) begin
      xlate(32'h00400000 | (32'(16 + i) << 12) | 32'h0AB, 1'b0, a, f);
      if (log_n != 0 || a != {20'hA0000 + 20'(i), 12'h0AB}) misses++;
    end
    chk(misses == 0, "R8", "all 32 slots hold", misses, 0);
    xlate(32'h00400000 | (32'd48 << 12), 1'b0, a, f);
    chk(log_n == 2 && a == 32'hA0020000, "R8", "33rd page fill", a, 32'hA0020000);
    xlate(32'h00400000 | (32'd17 << 12), 1'b0, a, f);
    chk(log_n == 0 && a == 32'hA0001000, "R8", "second page kept", log_n, 0);
    xlate(32'h00400000 | (32'd16 << 12), 1'b0, a, f);
    chk(log_n == 2 && a == 32'hA0000000, "R8", "first page evicted", log_n, 2);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    int drift = 0;
    rsp_ready = 1'b0;
    log_n = 0;
    @(negedge clk);
    req_lin = 32'h00412345; req_write = 1'b0; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    first = rsp_addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_addr != first || req_ready) drift++;
    end
    chk(drift == 0 && first == 32'hA0002345, "R10", "response held under stall", first, 32'hA0002345);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", "response released", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[32'h00010004] = 32'h00020001;
    mem[32'h00020004] = 32'h12345001;
    mem[32'h0002000C] = 32'h55555001;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_walk();
    t_hit();
    t_clean_write_hit();
    t_write_miss();
    t_faults();
    t_flush();
    t_round_robin();
    t_backpressure();
    chk(hold_err == 0, "R11", "memory request stable while waiting", hold_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule